// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is the read side of a two-wire serial slave. It watches the SCL and SDA pads through synchronizers and recognises its own 7-bit address, or optionally the general call address 0x00, when the master asks to read. It then sends data bytes to the master, MSB first. It drives each pad through an open-drain style enable: a 1 pulls the line low.

The block handles every bus step the same way. It halts, raises an interrupt flag and publishes an 8-bit status code. It keeps SCL low until the host writes 1 to the flag bit. When the flag is cleared after an address or data step, the block takes the next byte from the transmit data register. The acknowledge-enable bit has two jobs. It gates address recognition. When it is 0 at the moment a byte is loaded, that byte is marked as the last one, and the block then returns all ones if the master keeps reading.

The host register map, with a 2-bit address, is:
- 0: bits 7:1 own address, bit 0 general call enable.
- 1: bit 0 flag (a written 1 clears it), bit 1 acknowledge-enable.
- 2: transmit byte.
- 3: status (read only).

Top module: `i2c_rd_slave`

## Requirements
- R1: After reset, scl_oe, sda_oe and irq are 0 and register 3 reads 0xF8.
- R2: Whenever the flag is clear, register 3 reads 0xF8.
- R3: If the address byte matches register 0 bits 7:1, its last bit is 1 and register 1 bit 1 is 1, the block pulls SDA low in the acknowledge slot. It then sets the flag with status 0xA8. SCL stays low while the flag is set. Only a host write of 1 to register 1 bit 0 clears the flag.
- R4: While register 1 bit 1 is 0, a matching address gets no acknowledge and no flag. Once the bit is set again, the next matching address is served.
- R5: Address 0x00 with the read bit is acknowledged only while register 0 bit 0 is 1.
- R6: Each flag clear after status 0xA8 or 0xB8 loads register 2, which is then shifted out MSB first. A byte answered by ACK while it is not the last one gives status 0xB8.
- R7: A byte answered by NACK gives status 0xC0. After the flag clear, the block is not addressed and drives neither line.
- R8: A byte loaded while register 1 bit 1 is 0 is the last one. If the master ACKs it, status is 0xC8, and after the flag clear the master reads 0xFF.
- R9: sda_oe changes only while SCL is low.
- R10: A repeated START while addressed restarts address recognition. A non-matching address then leaves the block idle, with no acknowledge and no flag.
- R11: A matching address with the write bit (last bit 0) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions assume a master that keeps SCL low for longer than the synchronizer latency after each falling edge. They also assume the master changes SDA only while SCL is low, except when it makes a START or STOP, and that it honours stretching by waiting for SCL to read high. The bench master model meets these conditions by construction. It uses a half bit of 16 clocks and, after releasing SCL, polls the wired line until it rises. The host model reacts to the flag only from inside that polling loop, so every clearing write happens while SCL is held low.

// File: rtl/i2c_rd_slave_pkg.sv
package i2c_rd_slave_pkg;
   localparam int BYTE_W  = 8;
   localparam int SLA_W   = 7;
   localparam int CNT_W   = $clog2(BYTE_W);
   localparam int REG_AW  = 2;

   localparam logic [REG_AW-1:0] RA_ADDR = 2'd0;
   localparam logic [REG_AW-1:0] RA_CTRL = 2'd1;
   localparam logic [REG_AW-1:0] RA_TXD  = 2'd2;
   localparam logic [REG_AW-1:0] RA_STAT = 2'd3;

   localparam logic [BYTE_W-1:0] STS_ADDR_RD   = 8'hA8;
   localparam logic [BYTE_W-1:0] STS_DATA_ACK  = 8'hB8;
   localparam logic [BYTE_W-1:0] STS_DATA_NACK = 8'hC0;
   localparam logic [BYTE_W-1:0] STS_LAST_ACK  = 8'hC8;
   localparam logic [BYTE_W-1:0] STS_NONE      = 8'hF8;

   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_ADDR_END, S_ADDR_ACK,
      S_WAIT, S_TX_LOAD, S_TX_BITS, S_TX_ACK
   } eng_state_t;
endpackage

// File: rtl/i2c_rd_slave_sync.sv
module i2c_rd_slave_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES:0] chain;
   assign chain[0] = d;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= 1'b1;
         else        chain[i+1] <= chain[i];
      end
   end

   assign q = chain[STAGES];
endmodule

// File: rtl/i2c_rd_slave_evdet.sv
module i2c_rd_slave_evdet (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rd_slave_regs.sv
module i2c_rd_slave_regs
   import i2c_rd_slave_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              set_flag,
   input  logic [BYTE_W-1:0] set_code,
   output logic [SLA_W-1:0]  own_addr,
   output logic              gc_en,
   output logic              ack_en,
   output logic              ack_nx,
   output logic [BYTE_W-1:0] tx_data,
   output logic              flag,
   output logic              host_clr
);
   logic [BYTE_W-1:0] code_q;
   logic              ctrl_wr;

   assign ctrl_wr  = reg_we && (reg_addr == RA_CTRL);
   assign host_clr = ctrl_wr && reg_wdata[0] && flag;
   assign ack_nx   = ctrl_wr ? reg_wdata[1] : ack_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_addr <= '0;
         gc_en    <= 1'b0;
         ack_en   <= 1'b0;
         tx_data  <= '0;
         flag     <= 1'b0;
         code_q   <= STS_NONE;
      end else begin
         if (reg_we && reg_addr == RA_ADDR) begin
            own_addr <= reg_wdata[BYTE_W-1:1];
            gc_en    <= reg_wdata[0];
         end
         if (ctrl_wr)                        ack_en  <= reg_wdata[1];
         if (reg_we && reg_addr == RA_TXD)   tx_data <= reg_wdata;
         if (set_flag) begin
            flag   <= 1'b1;
            code_q <= set_code;
         end else if (host_clr) begin
            flag   <= 1'b0;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         RA_ADDR: reg_rdata = {own_addr, gc_en};
         RA_CTRL: reg_rdata = {6'd0, ack_en, flag};
         RA_TXD:  reg_rdata = tx_data;
         default: reg_rdata = flag ? code_q : STS_NONE;
      endcase
   end
endmodule

// File: rtl/i2c_rd_slave_engine.sv
module i2c_rd_slave_engine
   import i2c_rd_slave_pkg::*;
#(
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [SLA_W-1:0]  own_addr,
   input  logic              gc_en,
   input  logic              ack_en,
   input  logic              ack_nx,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              host_clr,
   output logic              set_flag,
   output logic [BYTE_W-1:0] set_code,
   output logic              sda_drive,
   output logic              hold_scl
);
   eng_state_t        st;
   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              last_q, nack_q, cont_q;
   logic              gc_hit, addr_hit, on_bus;

   if (GC_SUPPORT) begin : g_gc
      assign gc_hit = gc_en && (sh[BYTE_W-1:1] == '0);
   end else begin : g_nogc
      assign gc_hit = 1'b0;
   end

   assign addr_hit = ack_en && sh[0] && ((sh[BYTE_W-1:1] == own_addr) || gc_hit);
   assign on_bus   = (st != S_IDLE) && (st != S_WAIT) && (st != S_TX_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         sh       <= '0;
         cnt      <= '0;
         last_q   <= 1'b0;
         nack_q   <= 1'b0;
         cont_q   <= 1'b0;
         set_flag <= 1'b0;
         set_code <= STS_NONE;
      end else begin
         set_flag <= 1'b0;
         if (on_bus && (start_det || stop_det)) begin
            st  <= start_det ? S_ADDR : S_IDLE;
            cnt <= '0;
         end else begin
            case (st)
               S_IDLE: begin
                  if (start_det) begin
                     st  <= S_ADDR;
                     cnt <= '0;
                  end
               end
               S_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                     if (cnt == CNT_W'(BYTE_W-1)) st <= S_ADDR_END;
                  end
               end
               S_ADDR_END: begin
                  if (scl_fall) st <= addr_hit ? S_ADDR_ACK : S_IDLE;
               end
               S_ADDR_ACK: begin
                  if (scl_fall) begin
                     st       <= S_WAIT;
                     set_flag <= 1'b1;
                     set_code <= STS_ADDR_RD;
                     cont_q   <= 1'b1;
                  end
               end
               S_WAIT: begin
                  if (host_clr) begin
                     if (cont_q) begin
                        st     <= S_TX_LOAD;
                        sh     <= tx_data;
                        last_q <= ~ack_nx;
                        cnt    <= '0;
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               S_TX_LOAD: st <= S_TX_BITS;
               S_TX_BITS: begin
                  if (scl_fall) begin
                     if (cnt == CNT_W'(BYTE_W-1)) begin
                        st <= S_TX_ACK;
                     end else begin
                        sh  <= {sh[BYTE_W-2:0], 1'b1};
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               S_TX_ACK: begin
                  if (scl_rise) nack_q <= sda_s;
                  if (scl_fall) begin
                     st       <= S_WAIT;
                     set_flag <= 1'b1;
                     set_code <= nack_q ? STS_DATA_NACK :
                                 (last_q ? STS_LAST_ACK : STS_DATA_ACK);
                     cont_q   <= ~nack_q & ~last_q;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   assign sda_drive = (st == S_ADDR_ACK) ||
                      (((st == S_TX_LOAD) || (st == S_TX_BITS)) && !sh[BYTE_W-1]);
   assign hold_scl  = (st == S_TX_LOAD);
endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
   import i2c_rd_slave_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit GC_SUPPORT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   output logic              irq
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic set_flag, gc_en, ack_en, ack_nx, flag, host_clr, sda_drive, hold_scl;
   logic [BYTE_W-1:0] set_code, tx_data;
   logic [SLA_W-1:0]  own_addr;

   i2c_rd_slave_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2c_rd_slave_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2c_rd_slave_evdet u_evdet (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2c_rd_slave_regs u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .set_flag(set_flag), .set_code(set_code),
      .own_addr(own_addr), .gc_en(gc_en), .ack_en(ack_en), .ack_nx(ack_nx),
      .tx_data(tx_data), .flag(flag), .host_clr(host_clr));

   i2c_rd_slave_engine #(.GC_SUPPORT(GC_SUPPORT)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
      .own_addr(own_addr), .gc_en(gc_en), .ack_en(ack_en), .ack_nx(ack_nx),
      .tx_data(tx_data), .host_clr(host_clr),
      .set_flag(set_flag), .set_code(set_code),
      .sda_drive(sda_drive), .hold_scl(hold_scl));

   assign scl_oe = flag | hold_scl;
   assign sda_oe = sda_drive;
   assign irq    = flag;
endmodule

// File: rtl/i2c_rd_slave_chk.sv
module i2c_rd_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_i,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       reg_we,
   input logic [1:0] reg_addr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       irq
);
   p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   p_flag_stretches_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> scl_oe);

   p_flag_host_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(reg_we && reg_addr == 2'd1 && reg_wdata[0]));

   p_idle_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && reg_addr == 2'd3) |-> reg_rdata == 8'hF8);

   p_known_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && reg_addr == 2'd3) |->
      (reg_rdata == 8'hA8 || reg_rdata == 8'hB8 ||
       reg_rdata == 8'hC0 || reg_rdata == 8'hC8));

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!irq && !sda_oe));

   logic unused_ok;
   assign unused_ok = sda_i;
endmodule

bind i2c_rd_slave i2c_rd_slave_chk u_chk (.*);

// File: tb/sim_i2c_rd_slave.sv
module sim_i2c_rd_slave;
   localparam int CLK_PER = 10;
   localparam int HALF    = 16;
   localparam int WD_CYC  = 190000;
   localparam logic [6:0] OWN   = 7'h52;
   localparam logic [6:0] OTHER = 7'h47;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
   logic scl_oe, sda_oe, irq, reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd3;
   logic [7:0] reg_wdata = 8'd0, reg_rdata;
   wire scl_bus = ~(m_scl_lo | scl_oe);
   wire sda_bus = ~(m_sda_lo | sda_oe);

   int n_chk = 0, n_bad = 0, svc_hits = 0, r9_viol = 0;
   bit done = 1'b0, svc_armed = 1'b0, svc_ack = 1'b1;
   logic [7:0] svc_exp = 8'hF8, svc_data = 8'h00;
   string svc_tag = "R3";
   logic [7:0] tx_q [8];

   always #(CLK_PER/2) clk = ~clk;

   i2c_rd_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   // R9 monitor: the slave's SDA enable must not move while the bus SCL is high
   logic prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && (sda_oe != prev_oe) && scl_bus) r9_viol++;
      prev_oe = sda_oe;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 2'd3;
   endtask

   function automatic logic [7:0] ctrl_val(input bit ack, input bit clr);
      return {6'd0, ack, clr};
   endfunction

   task automatic host_service();
      logic [7:0] s;
      s = reg_rdata;
      chk(svc_armed ? svc_tag : "R3", s, svc_armed ? svc_exp : 8'hF8);
      if (s == 8'hA8 || s == 8'hB8) hwrite(2'd2, svc_data);
      hwrite(2'd1, ctrl_val(svc_ack, 1'b1));
      svc_armed = 1'b0;
      svc_hits++;
   endtask

   task automatic scl_up();
      m_scl_lo = 1'b0;
      while (!scl_bus) begin
         @(negedge clk);
         if (irq) host_service();
      end
   endtask

   task automatic mbit_w(input bit b);
      m_sda_lo = !b; cyc(HALF/2); scl_up(); cyc(HALF);
      m_scl_lo = 1'b1; cyc(HALF/2);
   endtask

   task automatic mbit_r(output bit b);
      m_sda_lo = 1'b0; cyc(HALF/2); scl_up(); cyc(HALF/2);
      b = sda_bus; cyc(HALF/2);
      m_scl_lo = 1'b1; cyc(HALF/2);
   endtask

   task automatic mstart();
      m_sda_lo = 1'b0; cyc(HALF/2); scl_up(); cyc(HALF);
      m_sda_lo = 1'b1; cyc(HALF);
      m_scl_lo = 1'b1; cyc(HALF/2);
   endtask

   task automatic mstop();
      m_sda_lo = 1'b1; cyc(HALF/2); scl_up(); cyc(HALF);
      m_sda_lo = 1'b0; cyc(HALF);
   endtask

   task automatic mbyte_w(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) mbit_w(v[i]);
   endtask

   task automatic mbyte_r(output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         mbit_r(b);
         v[i] = b;
      end
   endtask

   function automatic logic [7:0] exp_code(input int k, input int n, input bit lastm);
      if (k < n) return (k == 0) ? 8'hA8 : 8'hB8;
      return lastm ? 8'hC8 : 8'hC0;
   endfunction

   // full read: n bytes from tx_q; lastm selects the last-byte (C8) ending
   task automatic do_read(input logic [6:0] a, input int n, input bit lastm);
      bit b;
      logic [7:0] by;
      int h0;
      h0 = svc_hits;
      mstart();
      mbyte_w({a, 1'b1});
      mbit_r(b);
      chk("R3 ack", b, 0);
      for (int k = 0; k < n; k++) begin
         svc_armed = 1'b1; svc_exp = exp_code(k, n, lastm);
         svc_data = tx_q[k]; svc_ack = !(lastm && k == n-1);
         svc_tag = (k == 0) ? "R3" : "R6";
         mbyte_r(by);
         chk("R6 data", by, tx_q[k]);
         mbit_w(!lastm && k == n-1);
      end
      svc_armed = 1'b1; svc_exp = exp_code(n, n, lastm); svc_ack = 1'b1;
      svc_tag = lastm ? "R8" : "R7";
      if (lastm) begin
         mbyte_r(by);
         chk("R8 ones", by, 8'hFF);
         mbit_w(1'b1);
      end
      mstop();
      chk("R7 flags", svc_hits - h0, n + 1);
      chk("R7 released", {scl_oe, sda_oe, irq}, 0);
      chk("R2 idle status", reg_rdata, 8'hF8);
   endtask

   task automatic probe_nack(input logic [7:0] abyte, input string tag);
      bit b;
      mstart();
      mbyte_w(abyte);
      mbit_r(b);
      chk(tag, b, 1);
      mstop();
      chk(tag, irq, 0);
   endtask

   initial begin
      bit b;
      logic [7:0] by;
      int n;
      bit lm;
      void'($urandom(32'd24681));
      cyc(10);
      chk("R1 outputs", {scl_oe, sda_oe, irq}, 0);
      chk("R1 status", reg_rdata, 8'hF8);
      rst_n = 1'b1;
      cyc(4);
      chk("R2 status", reg_rdata, 8'hF8);
      hwrite(2'd0, {OWN, 1'b0});
      hwrite(2'd1, ctrl_val(1'b1, 1'b0));

      tx_q[0] = 8'hA5; tx_q[1] = 8'h01; tx_q[2] = 8'h80;
      do_read(OWN, 3, 1'b0);
      tx_q[0] = 8'h5A; tx_q[1] = 8'h00;
      do_read(OWN, 2, 1'b1);

      hwrite(2'd1, ctrl_val(1'b0, 1'b0));
      probe_nack({OWN, 1'b1}, "R4 disabled");
      hwrite(2'd1, ctrl_val(1'b1, 1'b0));
      tx_q[0] = 8'h3C;
      do_read(OWN, 1, 1'b0);

      probe_nack({OWN, 1'b0}, "R11 write dir");

      hwrite(2'd0, {OWN, 1'b1});
      tx_q[0] = 8'hC3;
      do_read(7'h00, 1, 1'b0);
      hwrite(2'd0, {OWN, 1'b0});
      probe_nack(8'h01, "R5 gc off");

      // R10: repeated START while addressed, then a foreign address
      mstart();
      mbyte_w({OWN, 1'b1});
      mbit_r(b);
      chk("R10 ack", b, 0);
      svc_armed = 1'b1; svc_exp = 8'hA8; svc_data = 8'hFF; svc_ack = 1'b1; svc_tag = "R3";
      mbyte_r(by);
      chk("R10 data", by, 8'hFF);
      mbit_w(1'b0);
      svc_armed = 1'b1; svc_exp = 8'hB8; svc_data = 8'hFF; svc_tag = "R6";
      mstart();
      mbyte_w({OTHER, 1'b1});
      mbit_r(b);
      chk("R10 foreign nack", b, 1);
      mstop();
      chk("R10 idle", {irq, sda_oe, scl_oe}, 0);

      for (int t = 0; t < 24; t++) begin
         n  = 1 + int'($urandom % 4);
         lm = bit'($urandom % 2);
         for (int k = 0; k < 8; k++) tx_q[k] = 8'($urandom);
         do_read(OWN, n, lm);
      end

      chk("R9 sda moves", r9_viol, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule